// File: doc/BRIEF.md
# I2C Serial Clock Timing Generator

This block derives the timing of an I2C serial clock from a fast functional clock. A programmable prescaler divides the functional clock into a slower internal sampling tick. Two counters then time the low and high halves of each SCL period in units of that tick. Each counter adds its own fixed trim to the programmed value: seven ticks for the low half and five ticks for the high half. Standard mode uses equal low and high counts. Fast mode uses a low half of about two thirds of the period.

A high-speed mode is also provided. In this mode each 16-bit count input holds two 8-bit values. The lower byte times the first, master-code, phase. The upper byte times the second, high-speed, phase. A live phase-select input picks the active byte. Software sets the prescaler and both counts while the enable is low. The block takes a copy of them when the enable is raised.

The outputs drive a bit-level engine. `tick` is the sampling-clock enable. `scl_req` is the requested SCL level, where 1 means released. `scl_rise` and `scl_fall` are one-cycle strobes on the SCL edges. All pins are plain control and status levels. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `scl_clkgen`

## Requirements
- R1: While `en` is low, and from the first clock after `en` is sampled low, `scl_req` is 1 and `tick`, `scl_rise` and `scl_fall` are 0. This is also the state after reset.
- R2: While enabled, `tick` is a one-cycle pulse once every `psc`+1 functional clock cycles. With `psc`=0 it is high every cycle.
- R3: With `hs_mode`=0, each low half of SCL (`scl_req`=0) lasts (`low_cnt`+7)*(`psc`+1) cycles, using all 16 bits of `low_cnt`.
- R4: With `hs_mode`=0, each high half of SCL after the first lasts (`high_cnt`+5)*(`psc`+1) cycles, using all 16 bits of `high_cnt`.
- R5: After `en` is sampled high, SCL starts in its high half. The first falling edge comes (`high_cnt`+5)*(`psc`+1) cycles later, counted from the cycle after that sampling edge.
- R6: `scl_fall` is high for exactly the first cycle in which `scl_req` is 0. `scl_rise` is high for exactly the first cycle in which `scl_req` is 1 again. The two are never high together.
- R7: With `hs_mode`=1 and `hs_phase2`=0, the low half uses `low_cnt[7:0]` and the high half uses `high_cnt[7:0]`, with the trims of R3 and R4.
- R8: With `hs_mode`=1 and `hs_phase2`=1, the halves use `low_cnt[15:8]` and `high_cnt[15:8]`. `hs_phase2` is not copied and acts on the half in progress.
- R9: `psc`, `low_cnt` and `high_cnt` are copied on the cycle `en` is first sampled high. Changes to them while enabled have no effect until `en` is dropped and raised again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Module enable; rising level loads configuration |
| hs_mode | input | 1 | 1 selects two-phase high-speed timing |
| hs_phase2 | input | 1 | In high-speed mode, 1 selects the second-phase byte |
| psc | input | 8 | Prescaler; tick period is psc+1 cycles |
| low_cnt | input | 16 | Low-half count (two bytes in high-speed mode) |
| high_cnt | input | 16 | High-half count (two bytes in high-speed mode) |
| tick | output | 1 | Internal sampling-clock enable pulse |
| scl_req | output | 1 | Requested SCL level, 1 = released |
| scl_rise | output | 1 | Strobe in the first cycle of the high half |
| scl_fall | output | 1 | Strobe in the first cycle of the low half |

## Verification
The low and high widths are measured in cycles for four settings. A symmetric setting with a prescaler of 1 checks the basic timing. The minimal setting, zero counts with no prescaling, exposes any error in the trims. An asymmetric fast-mode setting with a prescaler of 2 shows that the low and high counts are not swapped and that the prescaler multiplies both halves. A high-speed setting whose bytes all differ shows which byte drives each phase, before and after `hs_phase2` changes. A change to the counts while enabled, followed by a disable and a re-enable, separates the copy-on-enable behaviour from live use of the inputs. The delay to the first falling edge and the spacing of the ticks are measured separately.

// File: rtl/scl_pkg.sv
package scl_pkg;
  localparam int TRIM_LOW  = 7;
  localparam int TRIM_HIGH = 5;

  typedef enum logic { PH_LOW = 1'b0, PH_HIGH = 1'b1 } scl_phase_e;
endpackage

// File: rtl/scl_cfg_hold.sv
module scl_cfg_hold #(
  parameter int PSC_W = 8,
  parameter int CNT_W = 16,
  parameter int HS_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             hs_mode,
  input  logic             hs_phase2,
  input  logic [PSC_W-1:0] psc_in,
  input  logic [CNT_W-1:0] low_in,
  input  logic [CNT_W-1:0] high_in,
  output logic [PSC_W-1:0] psc_q,
  output logic [CNT_W-1:0] low_sel,
  output logic [CNT_W-1:0] high_sel
);
  localparam int PAD_W = CNT_W - HS_W;

  logic [CNT_W-1:0] low_q, high_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_q  <= '0;
      low_q  <= '0;
      high_q <= '0;
    end else if (load) begin
      psc_q  <= psc_in;
      low_q  <= low_in;
      high_q <= high_in;
    end
  end

  logic [HS_W-1:0] low_byte, high_byte;

  always_comb begin
    if (hs_phase2) begin
      low_byte  = low_q[2*HS_W-1:HS_W];
      high_byte = high_q[2*HS_W-1:HS_W];
    end else begin
      low_byte  = low_q[HS_W-1:0];
      high_byte = high_q[HS_W-1:0];
    end
  end

  always_comb begin
    if (hs_mode) begin
      low_sel  = {{PAD_W{1'b0}}, low_byte};
      high_sel = {{PAD_W{1'b0}}, high_byte};
    end else begin
      low_sel  = low_q;
      high_sel = high_q;
    end
  end
endmodule

// File: rtl/scl_tick_div.sv
module scl_tick_div #(
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             run,
  input  logic [PSC_W-1:0] psc_q,
  output logic             tick
);
  logic [PSC_W-1:0] pc;
  logic             wrap;

  assign wrap = (pc == psc_q);
  assign tick = run && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pc <= '0;
    else if (!en || !run) pc <= '0;
    else if (wrap)       pc <= '0;
    else                 pc <= pc + 1'b1;
  end
endmodule

// File: rtl/scl_phase_ctr.sv
module scl_phase_ctr
  import scl_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] low_sel,
  input  logic [CNT_W-1:0] high_sel,
  output logic             scl_req,
  output logic             scl_rise,
  output logic             scl_fall
);
  localparam int CW = CNT_W + 1;

  scl_phase_e     ph;
  logic [CW-1:0]  cnt;
  logic [CW-1:0]  last;

  always_comb begin
    if (ph == PH_LOW) last = {1'b0, low_sel}  + CW'(TRIM_LOW - 1);
    else              last = {1'b0, high_sel} + CW'(TRIM_HIGH - 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= PH_HIGH;
      cnt      <= '0;
      scl_rise <= 1'b0;
      scl_fall <= 1'b0;
    end else if (!en || !run) begin
      ph       <= PH_HIGH;
      cnt      <= '0;
      scl_rise <= 1'b0;
      scl_fall <= 1'b0;
    end else begin
      scl_rise <= 1'b0;
      scl_fall <= 1'b0;
      if (tick) begin
        if (cnt >= last) begin
          cnt <= '0;
          if (ph == PH_LOW) begin
            ph       <= PH_HIGH;
            scl_rise <= 1'b1;
          end else begin
            ph       <= PH_LOW;
            scl_fall <= 1'b1;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign scl_req = (ph == PH_HIGH);
endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen #(
  parameter int PSC_W = 8,
  parameter int CNT_W = 16,
  parameter int HS_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             hs_mode,
  input  logic             hs_phase2,
  input  logic [PSC_W-1:0] psc,
  input  logic [CNT_W-1:0] low_cnt,
  input  logic [CNT_W-1:0] high_cnt,
  output logic             tick,
  output logic             scl_req,
  output logic             scl_rise,
  output logic             scl_fall
);
  logic             run;
  logic             load;
  logic [PSC_W-1:0] psc_q;
  logic [CNT_W-1:0] low_sel, high_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= 1'b0;
    else        run <= en;
  end

  assign load = en && !run;

  scl_cfg_hold #(.PSC_W(PSC_W), .CNT_W(CNT_W), .HS_W(HS_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(load),
    .hs_mode(hs_mode), .hs_phase2(hs_phase2),
    .psc_in(psc), .low_in(low_cnt), .high_in(high_cnt),
    .psc_q(psc_q), .low_sel(low_sel), .high_sel(high_sel)
  );

  scl_tick_div #(.PSC_W(PSC_W)) u_div (
    .clk(clk), .rst_n(rst_n), .en(en), .run(run),
    .psc_q(psc_q), .tick(tick)
  );

  scl_phase_ctr #(.CNT_W(CNT_W)) u_ph (
    .clk(clk), .rst_n(rst_n), .en(en), .run(run), .tick(tick),
    .low_sel(low_sel), .high_sel(high_sel),
    .scl_req(scl_req), .scl_rise(scl_rise), .scl_fall(scl_fall)
  );
endmodule

// File: rtl/scl_clkgen_chk.sv
module scl_clkgen_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic tick,
  input logic scl_req,
  input logic scl_rise,
  input logic scl_fall
);
  AST_OFF_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (scl_req && !tick && !scl_rise && !scl_fall)); // R1

  AST_TICK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> $past(en)); // R2

  AST_EDGE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_rise || scl_fall) |-> $past(tick)); // R2

  AST_ONE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !(scl_rise && scl_fall)); // R6

  AST_FALL_IS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    scl_fall |-> (!scl_req && $past(scl_req))); // R6

  AST_RISE_IS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    scl_rise |-> (scl_req && !$past(scl_req))); // R6

  AST_CHANGE_STROBED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && (scl_req != $past(scl_req))) |-> (scl_rise || scl_fall)); // R6
endmodule

bind scl_clkgen scl_clkgen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .tick(tick),
  .scl_req(scl_req), .scl_rise(scl_rise), .scl_fall(scl_fall)
);

// File: tb/sim_scl_clkgen.sv
module sim_scl_clkgen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        hs_mode = 1'b0;
  logic        hs_phase2 = 1'b0;
  logic [7:0]  psc = '0;
  logic [15:0] low_cnt = '0;
  logic [15:0] high_cnt = '0;
  logic        tick, scl_req, scl_rise, scl_fall;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  scl_clkgen u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .hs_mode(hs_mode), .hs_phase2(hs_phase2),
    .psc(psc), .low_cnt(low_cnt), .high_cnt(high_cnt),
    .tick(tick), .scl_req(scl_req), .scl_rise(scl_rise), .scl_fall(scl_fall)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic low_width(output int w);
    int guard = 0;
    while (!scl_fall && guard < 20000) begin @(negedge clk); guard++; end
    w = 0;
    do begin w++; @(negedge clk); end while (!scl_req && w < 20000);
  endtask

  task automatic high_width(output int w);
    int guard = 0;
    while (!scl_rise && guard < 20000) begin @(negedge clk); guard++; end
    w = 0;
    do begin w++; @(negedge clk); end while (scl_req && w < 20000);
  endtask

  task automatic start(input logic hs, input logic p2, input int p, input int lo, input int hi);
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    hs_mode = hs; hs_phase2 = p2;
    psc = 8'(p); low_cnt = 16'(lo); high_cnt = 16'(hi);
    en = 1'b1;
  endtask

  task automatic t_reset;
    check("R1 reset scl_req", int'(scl_req), 1);
    check("R1 reset tick", int'(tick), 0);
    check("R1 reset strobes", int'(scl_rise | scl_fall), 0);
  endtask

  task automatic t_symmetric;
    int w;
    start(1'b0, 1'b0, 1, 3, 3);
    low_width(w);  check("R3 low psc1", w, 20);
    high_width(w); check("R4 high psc1", w, 16);
  endtask

  task automatic t_minimal;
    int w;
    start(1'b0, 1'b0, 0, 0, 0);
    @(negedge clk);
    check("R2 tick every cycle", int'(tick), 1);
    low_width(w);  check("R3 low minimal", w, 7);
    high_width(w); check("R4 high minimal", w, 5);
  endtask

  task automatic t_fast;
    int w;
    start(1'b0, 1'b0, 2, 7, 1);
    low_width(w);  check("R3 low fast", w, 42);
    high_width(w); check("R4 high fast", w, 18);
  endtask

  task automatic t_first_edge;
    int w = 0;
    start(1'b0, 1'b0, 1, 4, 2);
    @(negedge clk);
    while (scl_req && w < 20000) begin w++; @(negedge clk); end
    check("R5 first fall delay", w, 14);
    check("R6 fall strobe with low", int'(scl_fall), 1);
    @(negedge clk);
    check("R6 fall strobe one cycle", int'(scl_fall), 0);
  endtask

  task automatic t_tick_spacing;
    int w = 0;
    int guard = 0;
    start(1'b0, 1'b0, 3, 0, 0);
    @(negedge clk);
    while (!tick && guard < 100) begin @(negedge clk); guard++; end
    do begin w++; @(negedge clk); end while (!tick && w < 100);
    check("R2 tick spacing psc3", w, 4);
  endtask

  task automatic t_hs;
    int w;
    start(1'b1, 1'b0, 0, 16'h0203, 16'h0401);
    low_width(w);  check("R7 hs phase1 low", w, 10);
    high_width(w); check("R7 hs phase1 high", w, 6);
    hs_phase2 = 1'b1;
    high_width(w);
    low_width(w);  check("R8 hs phase2 low", w, 9);
    high_width(w); check("R8 hs phase2 high", w, 9);
  endtask

  task automatic t_hold;
    int w;
    start(1'b0, 1'b0, 0, 3, 2);
    low_width(w); check("R3 low before change", w, 10);
    low_cnt = 16'd40; psc = 8'd5; high_cnt = 16'd30;
    high_width(w); check("R9 high ignores live change", w, 7);
    low_width(w);  check("R9 low ignores live change", w, 10);
    @(negedge clk); en = 1'b0;
    @(negedge clk);
    check("R1 released after disable", int'(scl_req), 1);
    check("R1 tick off after disable", int'(tick), 0);
    en = 1'b1;
    low_width(w);  check("R9 new low after re-enable", w, 47 * 6);
  endtask

  initial begin
    while (1) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_bad++; n_chk++;
        $display("FAIL watchdog: actual %0d expected below 150000", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_symmetric;
    t_minimal;
    t_fast;
    t_first_edge;
    t_tick_spacing;
    t_hs;
    t_hold;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule